// File: doc/BRIEF.md
# I/O Translation Configuration Register Bank

This block is the software-visible configuration store for an I/O address translator. A host reaches it through a simple memory-mapped slave port. The port carries 32-bit words and takes byte offsets whose two lowest bits are ignored. Each register keeps only its writable bits, and some registers add constant fields. The bank hands its live configuration straight to the translator: the enable bit, the page-table base, one bypass bit per device slot, and the base of the translated address window.

The window base is decoded from a 3-bit size code in the control register. Each size is a power of two from 16 MB up to 2 GB, and the window always ends at the top of the 32-bit address space. The translator reports faults back through a capture strobe that loads the fault status and fault address registers. A capture wins over a software write to those registers made in the same cycle.

The fields for bus arbitration and burst capability are only stored; nothing in this block acts on them. Every access is accepted at once, and its response comes one cycle later.

Top module: `iotx_cfg_bank`

## Requirements
- R1: After reset, the control register reads 0x04000000 and every other register reads 0. The enable output, window base, page-table base and bypass outputs are all 0.
- R2: Control register (offset 0x0000): only bits 0, 2, 3 and 4 store written data (mask 0x0000001d). Bits 27:24 always read 4 and all other bits read 0. Bit 0 drives xl_enable.
- R3: A write to the control register with size code c = bits 4:2 sets xl_window_base to 2^32 - 2^(24+c), which is 0xff000000 for c=0 and 0x80000000 for c=7. No other access changes the window base.
- R4: Page-table base register (offset 0x0004): only bits 0x07fffc00 are stored. The stored value drives xl_pt_base.
- R5: The registers at offsets 0x0014 and 0x0018 store and return the full 32-bit written value.
- R6: Slot register i (offset 0x1010 + 4*i, i = 0..3) keeps only mask 0x00010003. Its bit 0 drives xl_bypass[i].
- R7: Register at offset 0x2000: only bits 0x001f0000 are stored. After any write to it, bit 3 reads 1.
- R8: Offsets other than the ones listed in R2 to R10 read 0, and writes to them change no register.
- R9: Fault status (offset 0x1000) and fault address (offset 0x1004) take full 32-bit software writes. A cycle with flt_valid high loads flt_status and flt_addr into them.
- R10: When flt_valid and a software write to the fault status or fault address register fall in the same cycle, the captured fault value is stored and the software value is dropped.
- R11: req_ready is always high. rsp_valid is high exactly in the cycle after each cycle with req_valid high. rsp_rdata then holds the read value, or 0 for a write.
- R12: Byte-offset bits 1:0 are ignored, so any offset inside a word selects that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Access accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (14) | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| flt_valid | input | 1 | Fault capture strobe from the translator |
| flt_status | input | 32 | Fault status word to capture |
| flt_addr | input | 32 | Faulting address to capture |
| xl_enable | output | 1 | Translation enable |
| xl_window_base | output | 32 | Start of the translated window |
| xl_pt_base | output | 32 | Page-table base (masked) |
| xl_bypass | output | SLOTS (4) | Per-slot bypass bits |

## Verification
The bench steps through all eight size codes. A design that got the shift off by one, or filled the window base from the wrong end, would give a misaligned or inverted window base. Every masked register is written with all ones and read back. A wrong mask would leak stray bits, and a lost constant would drop the version nibble or the forced bit 3. A same-cycle capture and software write to the fault-address register is checked: with the priority reversed, the software value would appear. Writes to undecoded offsets and to unaligned offsets are checked as well. A design with loose decoding would corrupt a real register or return stale data.

// File: rtl/iotx_cfg_pkg.sv
package iotx_cfg_pkg;

    localparam int unsigned WORD_W = 32;

    // word indices (byte offset >> 2); the translator and software depend on these
    localparam int unsigned WIDX_CTRL  = 'h000;
    localparam int unsigned WIDX_PTB   = 'h001;
    localparam int unsigned WIDX_TLBF  = 'h005;
    localparam int unsigned WIDX_PGF   = 'h006;
    localparam int unsigned WIDX_FSTAT = 'h400;
    localparam int unsigned WIDX_FADDR = 'h401;
    localparam int unsigned WIDX_SLOT0 = 'h404;
    localparam int unsigned WIDX_ARB   = 'h800;

    localparam logic [WORD_W-1:0] CTRL_KEEP   = 32'h0000_001d;
    localparam logic [WORD_W-1:0] CTRL_VER    = 32'h0400_0000;
    localparam logic [WORD_W-1:0] PTB_KEEP    = 32'h07ff_fc00;
    localparam logic [WORD_W-1:0] SLOT_KEEP   = 32'h0001_0003;
    localparam logic [WORD_W-1:0] ARB_KEEP    = 32'h001f_0000;
    localparam logic [WORD_W-1:0] ARB_FORCED  = 32'h0000_0008;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PTB,
        SEL_TLBF,
        SEL_PGF,
        SEL_FSTAT,
        SEL_FADDR,
        SEL_SLOT,
        SEL_ARB
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] addr;
    } fault_cap_t;

    // Start of a window of 2^(24+code) bytes ending at the top of the space
    function automatic logic [WORD_W-1:0] window_base_of(input logic [2:0] code);
        return {WORD_W{1'b1}} << (24 + int'(code));
    endfunction

endpackage

// File: rtl/iotx_cfg_decode.sv
module iotx_cfg_decode
    import iotx_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned SLOTS  = 4,
    localparam int unsigned WIDX_W = ADDR_W - 2,
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [SLOT_W-1:0] slot_idx
);
    localparam logic [WIDX_W-1:0] W_CTRL  = WIDX_W'(WIDX_CTRL);
    localparam logic [WIDX_W-1:0] W_PTB   = WIDX_W'(WIDX_PTB);
    localparam logic [WIDX_W-1:0] W_TLBF  = WIDX_W'(WIDX_TLBF);
    localparam logic [WIDX_W-1:0] W_PGF   = WIDX_W'(WIDX_PGF);
    localparam logic [WIDX_W-1:0] W_FSTAT = WIDX_W'(WIDX_FSTAT);
    localparam logic [WIDX_W-1:0] W_FADDR = WIDX_W'(WIDX_FADDR);
    localparam logic [WIDX_W-1:0] W_SLOT0 = WIDX_W'(WIDX_SLOT0);
    localparam logic [WIDX_W-1:0] W_ARB   = WIDX_W'(WIDX_ARB);

    logic [WIDX_W-1:0] widx;
    assign widx = addr[ADDR_W-1:2];

    always_comb begin
        sel      = SEL_NONE;
        slot_idx = '0;
        if (widx == W_CTRL)       sel = SEL_CTRL;
        else if (widx == W_PTB)   sel = SEL_PTB;
        else if (widx == W_TLBF)  sel = SEL_TLBF;
        else if (widx == W_PGF)   sel = SEL_PGF;
        else if (widx == W_FSTAT) sel = SEL_FSTAT;
        else if (widx == W_FADDR) sel = SEL_FADDR;
        else if (widx == W_ARB)   sel = SEL_ARB;
        for (int i = 0; i < SLOTS; i++) begin
            if (widx == W_SLOT0 + WIDX_W'(i)) begin
                sel      = SEL_SLOT;
                slot_idx = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/iotx_cfg_window.sv
module iotx_cfg_window
    import iotx_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              enable,
    output logic [WORD_W-1:0] win_base
);
    logic [WORD_W-1:0] kept_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kept_q   <= '0;
            win_base <= '0;
        end else if (wr_en) begin
            kept_q   <= wdata & CTRL_KEEP;
            win_base <= window_base_of(wdata[4:2]);
        end
    end

    assign ctrl_word = kept_q | CTRL_VER;
    assign enable    = kept_q[0];

    // R3
    win_base_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (win_base != '0) |-> (win_base[31] && win_base[23:0] == '0));
endmodule

// File: rtl/iotx_cfg_fault.sv
module iotx_cfg_fault
    import iotx_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr_stat,
    input  logic              sw_wr_addr,
    input  logic [WORD_W-1:0] wdata,
    input  fault_cap_t        cap,
    output logic [WORD_W-1:0] stat_q,
    output logic [WORD_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            addr_q <= '0;
        end else if (cap.valid) begin
            stat_q <= cap.status;
            addr_q <= cap.addr;
        end else begin
            if (sw_wr_stat) stat_q <= wdata;
            if (sw_wr_addr) addr_q <= wdata;
        end
    end

    // R10
    capture_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cap.valid |=> (addr_q == $past(cap.addr) && stat_q == $past(cap.status)));
endmodule

// File: rtl/iotx_cfg_slots.sv
module iotx_cfg_slots
    import iotx_cfg_pkg::*;
#(
    parameter int unsigned SLOTS = 4,
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [SLOT_W-1:0]            wr_idx,
    input  logic [WORD_W-1:0]            wdata,
    output logic [SLOTS-1:0][WORD_W-1:0] slot_q,
    output logic [SLOTS-1:0]             bypass
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (wr_en && wr_idx == SLOT_W'(g))
                slot_q[g] <= wdata & SLOT_KEEP;
        end
        assign bypass[g] = slot_q[g][0];
    end
endmodule

// File: rtl/iotx_cfg_bank.sv
module iotx_cfg_bank
    import iotx_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned SLOTS  = 4,
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              flt_valid,
    input  logic [31:0]       flt_status,
    input  logic [31:0]       flt_addr,
    output logic              xl_enable,
    output logic [31:0]       xl_window_base,
    output logic [31:0]       xl_pt_base,
    output logic [SLOTS-1:0]  xl_bypass
);
    reg_sel_e          sel;
    logic [SLOT_W-1:0] slot_idx;
    logic              wr;
    logic [WORD_W-1:0] ctrl_word, stat_q, faddr_q;
    logic [WORD_W-1:0] ptb_q, tlbf_q, pgf_q, arb_q, rd_word;
    logic [SLOTS-1:0][WORD_W-1:0] slot_q;
    fault_cap_t        cap;

    assign req_ready = 1'b1;
    assign wr        = req_valid && req_write;
    assign cap       = '{valid: flt_valid, status: flt_status, addr: flt_addr};

    iotx_cfg_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_decode (
        .addr(req_addr), .sel(sel), .slot_idx(slot_idx)
    );

    iotx_cfg_window u_window (
        .clk(clk), .rst(rst), .wr_en(wr && sel == SEL_CTRL), .wdata(req_wdata),
        .ctrl_word(ctrl_word), .enable(xl_enable), .win_base(xl_window_base)
    );

    iotx_cfg_fault u_fault (
        .clk(clk), .rst(rst),
        .sw_wr_stat(wr && sel == SEL_FSTAT), .sw_wr_addr(wr && sel == SEL_FADDR),
        .wdata(req_wdata), .cap(cap), .stat_q(stat_q), .addr_q(faddr_q)
    );

    iotx_cfg_slots #(.SLOTS(SLOTS)) u_slots (
        .clk(clk), .rst(rst), .wr_en(wr && sel == SEL_SLOT), .wr_idx(slot_idx),
        .wdata(req_wdata), .slot_q(slot_q), .bypass(xl_bypass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptb_q  <= '0;
            tlbf_q <= '0;
            pgf_q  <= '0;
            arb_q  <= '0;
        end else if (wr) begin
            case (sel)
                SEL_PTB:  ptb_q  <= req_wdata & PTB_KEEP;
                SEL_TLBF: tlbf_q <= req_wdata;
                SEL_PGF:  pgf_q  <= req_wdata;
                SEL_ARB:  arb_q  <= (req_wdata & ARB_KEEP) | ARB_FORCED;
                default:  ;
            endcase
        end
    end
    assign xl_pt_base = ptb_q;

    always_comb begin
        case (sel)
            SEL_CTRL:  rd_word = ctrl_word;
            SEL_PTB:   rd_word = ptb_q;
            SEL_TLBF:  rd_word = tlbf_q;
            SEL_PGF:   rd_word = pgf_q;
            SEL_FSTAT: rd_word = stat_q;
            SEL_FADDR: rd_word = faddr_q;
            SEL_SLOT:  rd_word = slot_q[slot_idx];
            SEL_ARB:   rd_word = arb_q;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
        end
    end

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R2
    ctrl_read_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && sel == SEL_CTRL) |=>
        (rsp_rdata[27:24] == 4'h4 && (rsp_rdata & 32'hf0ff_ffe2) == '0));
    // R3
    window_held_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel == SEL_CTRL) |=> $stable(xl_window_base));
endmodule

// File: tb/iotx_cfg_bank_tb.sv
module iotx_cfg_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_write = 0;
    logic [13:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        flt_valid = 0;
    logic [31:0] flt_status = '0, flt_addr = '0;
    logic        req_ready, rsp_valid, xl_enable;
    logic [31:0] rsp_rdata, xl_window_base, xl_pt_base;
    logic [3:0]  xl_bypass;

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    iotx_cfg_bank u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .flt_valid(flt_valid), .flt_status(flt_status), .flt_addr(flt_addr),
        .xl_enable(xl_enable), .xl_window_base(xl_window_base),
        .xl_pt_base(xl_pt_base), .xl_bypass(xl_bypass)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item for each response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected response", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, rsp_rdata, e);
            end
        end
    end

    task automatic access(input bit w, input logic [13:0] a, input logic [31:0] d,
                          input logic [31:0] exp, input string tag, input bit fault = 0,
                          input logic [31:0] fs = '0, input logic [31:0] fa = '0);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        flt_valid = fault; flt_status = fs; flt_addr = fa;
        exp_q.push_back(w ? 32'h0 : exp);
        tag_q.push_back(tag);
        @(posedge clk);
        #1 req_valid = 0; flt_valid = 0;
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d, input string tag);
        access(1, a, d, 0, tag);
    endtask
    task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string tag);
        access(0, a, 0, exp, tag);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 enable", {31'b0, xl_enable}, 0);
        chk("R1 window base", xl_window_base, 0);
        chk("R1 pt base", xl_pt_base, 0);
        chk("R1 bypass", {28'b0, xl_bypass}, 0);
        chk("R11 ready", {31'b0, req_ready}, 1);
        rd(14'h0000, 32'h0400_0000, "R1 ctrl reset");
        rd(14'h1000, 0, "R1 fault status reset");
        rd(14'h2000, 0, "R1 arb reset");
        rd(14'h1010, 0, "R1 slot reset");

        // R2 control masking
        wr(14'h0000, 32'hffff_ffff, "R2 write");
        rd(14'h0000, 32'h0400_001d, "R2 ctrl readback");
        settle();
        chk("R2 enable", {31'b0, xl_enable}, 1);
        chk("R3 code7", xl_window_base, 32'h8000_0000);

        // R3 every size code
        for (int c = 0; c < 8; c++) begin
            logic [31:0] e;
            wr(14'h0000, 32'(c << 2), "R3 write");
            settle();
            e = 32'(64'h1_0000_0000 - (64'h100_0000 << c));
            chk($sformatf("R3 code%0d", c), xl_window_base, e);
            chk("R2 enable off", {31'b0, xl_enable}, 0);
        end
        // R3 other writes leave it alone
        wr(14'h0004, 32'hffff_ffff, "R4 write");
        settle();
        chk("R3 hold", xl_window_base, 32'h8000_0000);

        // R4
        rd(14'h0004, 32'h07ff_fc00, "R4 readback");
        chk("R4 pt base out", xl_pt_base, 32'h07ff_fc00);

        // R5
        wr(14'h0014, 32'hdead_beef, "R5 write");
        wr(14'h0018, 32'h1234_5679, "R5 write");
        rd(14'h0014, 32'hdead_beef, "R5 tlb flush");
        rd(14'h0018, 32'h1234_5679, "R5 page flush");

        // R6
        for (int i = 0; i < 4; i++) wr(14'(14'h1010 + 4*i), 32'hffff_fffe, "R6 write");
        wr(14'h1018, 32'hffff_ffff, "R6 write");
        rd(14'h1010, 32'h0001_0002, "R6 slot0");
        rd(14'h1018, 32'h0001_0003, "R6 slot2");
        rd(14'h101c, 32'h0001_0002, "R6 slot3");
        settle();
        chk("R6 bypass", {28'b0, xl_bypass}, 32'h4);

        // R7
        wr(14'h2000, 32'hffff_ffff, "R7 write");
        rd(14'h2000, 32'h001f_0008, "R7 all ones");
        wr(14'h2000, 32'h0, "R7 write");
        rd(14'h2000, 32'h0000_0008, "R7 zero");

        // R8 undecoded
        wr(14'h0008, 32'hcafe_f00d, "R8 write");
        wr(14'h3ffc, 32'hcafe_f00d, "R8 write");
        rd(14'h0008, 0, "R8 read 0x8");
        rd(14'h3ffc, 0, "R8 read top");
        rd(14'h0004, 32'h07ff_fc00, "R8 ptb unchanged");
        rd(14'h0000, 32'h0400_001c, "R8 ctrl unchanged");

        // R12 low bits
        wr(14'h0017, 32'h0bad_f00d, "R12 write");
        rd(14'h0015, 32'h0bad_f00d, "R12 unaligned read");

        // R9
        wr(14'h1000, 32'h1111_2222, "R9 write");
        rd(14'h1000, 32'h1111_2222, "R9 sw status");
        access(0, 14'h0008, 0, 0, "R9 idle read", 1, 32'he280_0000, 32'h8765_4000);
        rd(14'h1000, 32'he280_0000, "R9 captured status");
        rd(14'h1004, 32'h8765_4000, "R9 captured addr");

        // R10 priority
        access(1, 14'h1004, 32'h5555_aaaa, 0, "R10 write", 1, 32'h9000_0000, 32'h0abc_d000);
        rd(14'h1004, 32'h0abc_d000, "R10 capture beats write");
        rd(14'h1000, 32'h9000_0000, "R10 status");

        settle();
        settle();
        chk("R11 all responses", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule